// File: doc/BRIEF.md
# Pipelined Cartesian Magnitude Unit

This block takes one pair of 16-bit Cartesian components every clock and returns the length of the vector, floor(sqrt(X² + Y²)), as a 16-bit unsigned value. The result comes out a fixed 24 cycles after the sample is captured. Each component is first reduced to a 15-bit absolute value and squared. The two squares are added into a 32-bit sum, and a sixteen-stage pipelined square root works on that sum. Read as fixed point, the inputs are fractions in [-1, 1). The output at unit scale has one integer bit and fifteen fraction bits, so it covers 0 up to just under 2.

A format bit is captured together with the data. It selects two's complement or sign-magnitude coding, and it may differ from one sample to the next. A two-bit scale control shifts the magnitude left by zero to three places. When the shifted value no longer fits in 16 bits, an overflow flag rises in the same cycle as that output, and the output saturates to all ones.

Each component has its own capture enable. A gate on the magnitude port stands in for a three-state pin: when the gate is closed, the port reads zero.

Top module: `cart_mag_pipe`

## Requirements
- R1: A sample present at clock edge n is reflected on `mag_out` and `ovr_out` right after edge n+24. A new sample is accepted at every edge.
- R2: At scale code 00, `mag_out` equals floor(sqrt(|X|² + |Y|²)), with |X| and |Y| taken as 15-bit absolute values. It is therefore never above 46340.
- R3: With `fmt_sm` low, an input is two's complement (16'h8000 is not a legal code). With it high, bit 15 is the sign and bits 14:0 are the magnitude. The format bit is captured with the data it describes.
- R4: `scale_sel` codes 00, 01, 10 and 11 shift the root left by 0, 1, 2 and 3 places. The code present at edge t governs the output updated at edge t+1. Code 00 never raises `ovr_out`.
- R5: `ovr_out` is high exactly when the root shifted by the selected amount exceeds 16'hFFFF. In that case `mag_out` is 16'hFFFF.
- R6: While `x_ce` is low, the captured X value and its format bit hold. `y_ce` does the same for Y. The pipeline keeps advancing with the held values.
- R7: While `mag_oe` is low, `mag_out` reads 0 in that same cycle. `ovr_out` and the pipeline are unaffected.
- R8: Reset clears every stage. `mag_out` and `ovr_out` are 0 during reset and stay 0 until the first post-reset sample arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_in | input | 16 | X component |
| y_in | input | 16 | Y component |
| fmt_sm | input | 1 | 0: two's complement, 1: sign-magnitude |
| x_ce | input | 1 | Capture enable for X and its format |
| y_ce | input | 1 | Capture enable for Y and its format |
| scale_sel | input | 2 | Left shift of the result: 0 to 3 places |
| mag_oe | input | 1 | Magnitude port gate; low forces zero |
| mag_out | output | 16 | Scaled magnitude |
| ovr_out | output | 1 | Scaled magnitude out of range |

## Verification
Fixed pairs such as 3/4 in both codings, all-zero, and the largest legal values pin down the root's rounding and its upper end. Each of these has exactly one right answer. Random full-range pairs with alternating format bits separate correct two's complement and sign-magnitude decoding from a decoder that ignores the format or reads the sign bit wrongly. Large components combined with scale codes that change every cycle show whether the overflow flag and the saturation line up with the one-cycle scale latency rather than with the data latency. Random enable and gate patterns show whether held components are reused and whether the gate touches only the magnitude port.

// File: rtl/cmag_pkg.sv
package cmag_pkg;
    localparam int IN_W   = 16;
    localparam int ABS_W  = IN_W - 1;
    localparam int SQ_W   = 2 * ABS_W;
    localparam int SUM_W  = 2 * IN_W;
    localparam int ROOT_W = SUM_W / 2;
    localparam int REM_W  = ROOT_W + 2;
    localparam int SCL_W  = 2;
    localparam int MAXSH  = (1 << SCL_W) - 1;

    // One stage of the digit-by-digit square root
    typedef struct packed {
        logic [REM_W-1:0]  rem;
        logic [ROOT_W-1:0] root;
        logic [SUM_W-1:0]  rad;
    } sqrt_st_t;

    // Front end and output registers of the top level
    typedef struct packed {
        logic [IN_W-1:0]   x;
        logic [IN_W-1:0]   y;
        logic              fx;
        logic              fy;
        logic [ABS_W-1:0]  ax;
        logic [ABS_W-1:0]  ay;
        logic [SQ_W-1:0]   sx;
        logic [SQ_W-1:0]   sy;
        logic [SUM_W-1:0]  sum;
        logic [SCL_W-1:0]  scale;
        logic [ROOT_W-1:0] mag;
        logic              ovr;
    } front_t;
endpackage

// File: rtl/cmag_absval.sv
module cmag_absval
    import cmag_pkg::*;
(
    input  logic [IN_W-1:0]  val_in,
    input  logic             sm_mode,
    output logic [ABS_W-1:0] abs_out
);
    logic [IN_W-1:0] neg_v;

    always_comb begin
        neg_v = -val_in;
        if (sm_mode) begin
            abs_out = val_in[ABS_W-1:0];
        end else if (val_in[IN_W-1]) begin
            abs_out = neg_v[ABS_W-1:0];
        end else begin
            abs_out = val_in[ABS_W-1:0];
        end
    end
endmodule

// File: rtl/cmag_isqrt.sv
module cmag_isqrt
    import cmag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SUM_W-1:0]  rad_in,
    output logic [ROOT_W-1:0] root_out
);
    for (genvar g = 0; g < ROOT_W; g++) begin : stg
        sqrt_st_t          s_in;
        sqrt_st_t          s_d;
        sqrt_st_t          s_q;
        logic [REM_W-1:0]  acc;
        logic [REM_W-1:0]  trial;

        if (g == 0) begin : g_first
            assign s_in = {{REM_W{1'b0}}, {ROOT_W{1'b0}}, rad_in};
        end else begin : g_next
            assign s_in = stg[g-1].s_q;
        end

        always_comb begin
            acc   = {s_in.rem[REM_W-3:0], s_in.rad[SUM_W-1 -: 2]};
            trial = {s_in.root, 2'b01};
            s_d.rad = s_in.rad << 2;
            if (acc >= trial) begin
                s_d.rem  = acc - trial;
                s_d.root = {s_in.root[ROOT_W-2:0], 1'b1};
            end else begin
                s_d.rem  = acc;
                s_d.root = {s_in.root[ROOT_W-2:0], 1'b0};
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end
    end

    assign root_out = stg[ROOT_W-1].s_q.root;

    logic unused_tail;
    assign unused_tail = ^{stg[ROOT_W-1].s_q.rem, stg[ROOT_W-1].s_q.rad};
endmodule

// File: rtl/cmag_scaler.sv
module cmag_scaler
    import cmag_pkg::*;
(
    input  logic [ROOT_W-1:0] root_in,
    input  logic [SCL_W-1:0]  shift_in,
    output logic [ROOT_W-1:0] mag_out,
    output logic              ovr_out
);
    logic [ROOT_W+MAXSH-1:0] wide;

    always_comb begin
        wide    = {{MAXSH{1'b0}}, root_in} << shift_in;
        ovr_out = |wide[ROOT_W+MAXSH-1:ROOT_W];
        mag_out = ovr_out ? {ROOT_W{1'b1}} : wide[ROOT_W-1:0];
    end
endmodule

// File: rtl/cart_mag_pipe.sv
module cart_mag_pipe
    import cmag_pkg::*;
#(
    parameter int LATENCY = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   x_in,
    input  logic [IN_W-1:0]   y_in,
    input  logic              fmt_sm,
    input  logic              x_ce,
    input  logic              y_ce,
    input  logic [SCL_W-1:0]  scale_sel,
    input  logic              mag_oe,
    output logic [ROOT_W-1:0] mag_out,
    output logic              ovr_out
);
    // Fixed register levels: capture, abs, square, sum, output
    localparam int FIXED_N = 5;
    localparam int PAD_N   = LATENCY + 1 - FIXED_N - ROOT_W;

    front_t            r_d, r_q;
    logic [ROOT_W-1:0] pad_d [PAD_N];
    logic [ROOT_W-1:0] pad_q [PAD_N];

    logic [ABS_W-1:0]  ax_w, ay_w;
    logic [ROOT_W-1:0] root_w;
    logic [ROOT_W-1:0] scl_mag;
    logic              scl_ovr;

    cmag_absval i_abs_x (.val_in(r_q.x), .sm_mode(r_q.fx), .abs_out(ax_w));
    cmag_absval i_abs_y (.val_in(r_q.y), .sm_mode(r_q.fy), .abs_out(ay_w));

    cmag_isqrt i_root (
        .clk     (clk),
        .rst_n   (rst_n),
        .rad_in  (r_q.sum),
        .root_out(root_w)
    );

    cmag_scaler i_scale (
        .root_in (pad_q[PAD_N-1]),
        .shift_in(r_q.scale),
        .mag_out (scl_mag),
        .ovr_out (scl_ovr)
    );

    always_comb begin
        r_d = r_q;
        if (x_ce) begin
            r_d.x  = x_in;
            r_d.fx = fmt_sm;
        end
        if (y_ce) begin
            r_d.y  = y_in;
            r_d.fy = fmt_sm;
        end
        r_d.ax    = ax_w;
        r_d.ay    = ay_w;
        r_d.sx    = SQ_W'(r_q.ax) * SQ_W'(r_q.ax);
        r_d.sy    = SQ_W'(r_q.ay) * SQ_W'(r_q.ay);
        r_d.sum   = SUM_W'(r_q.sx) + SUM_W'(r_q.sy);
        r_d.scale = scale_sel;
        r_d.mag   = scl_mag;
        r_d.ovr   = scl_ovr;

        pad_d[0] = root_w;
        for (int i = 1; i < PAD_N; i++) begin
            pad_d[i] = pad_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            for (int i = 0; i < PAD_N; i++) begin
                pad_q[i] <= '0;
            end
        end else begin
            r_q <= r_d;
            for (int i = 0; i < PAD_N; i++) begin
                pad_q[i] <= pad_d[i];
            end
        end
    end

    assign mag_out = mag_oe ? r_q.mag : '0;
    assign ovr_out = r_q.ovr;
endmodule

// File: rtl/cmag_check.sv
module cmag_check
    import cmag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SCL_W-1:0]  scale_sel,
    input logic              mag_oe,
    input logic [ROOT_W-1:0] mag_out,
    input logic              ovr_out
);
    assert_gate_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mag_oe |-> (mag_out == '0));

    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_out && mag_oe) |-> (mag_out == {ROOT_W{1'b1}}));

    assert_unit_no_ovr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scale_sel, 2) == '0) |-> !ovr_out);

    assert_unit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mag_oe && $past(scale_sel, 2) == '0) |-> (mag_out <= 16'd46340));

    assert_known_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({mag_out, ovr_out}));
endmodule

bind cart_mag_pipe cmag_check i_cmag_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .scale_sel(scale_sel),
    .mag_oe   (mag_oe),
    .mag_out  (mag_out),
    .ovr_out  (ovr_out)
);

// File: tb/test_cart_mag_pipe.sv
module test_cart_mag_pipe;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] x_in, y_in;
    logic        fmt_sm, x_ce, y_ce, mag_oe;
    logic [1:0]  scale_sel;
    logic [15:0] mag_out;
    logic        ovr_out;

    always #4 clk = ~clk;

    cart_mag_pipe i_cart_mag_pipe (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .y_in(y_in), .fmt_sm(fmt_sm),
        .x_ce(x_ce), .y_ce(y_ce), .scale_sel(scale_sel), .mag_oe(mag_oe),
        .mag_out(mag_out), .ovr_out(ovr_out)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    edge_n = 0;
    bit    done = 0;
    string cur_req = "R8";
    int    root_a [0:8191];
    int    scl_a  [0:8191];
    logic [15:0] hx = 16'h0, hy = 16'h0;
    logic        hfx = 1'b0, hfy = 1'b0;

    function automatic longint absv(logic [15:0] v, logic sm);
        int t;
        if (sm) return longint'(v[14:0]);
        t = v[15] ? (65536 - int'(v)) : int'(v);
        return longint'(t & 32'h7fff);
    endfunction

    function automatic int isqrt(longint s);
        longint r = 0;
        for (int b = 15; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= s) r = t;
        end
        return int'(r);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (edge %0d)", req, what, act, exp, edge_n);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Called at a falling edge: drive, model the next rising edge, compare.
    task automatic step(logic [15:0] x, logic [15:0] y, logic fs, logic xce,
                        logic yce, logic [1:0] sc, logic oe);
        int r, s, em, eo;
        longint ax, ay, full;
        if (!fs && x == 16'h8000) x = 16'h8001;
        if (!fs && y == 16'h8000) y = 16'h8001;
        x_in = x; y_in = y; fmt_sm = fs; x_ce = xce; y_ce = yce;
        scale_sel = sc; mag_oe = oe;
        @(posedge clk);
        edge_n++;
        if (xce) begin hx = x; hfx = fs; end
        if (yce) begin hy = y; hfy = fs; end
        ax = absv(hx, hfx);
        ay = absv(hy, hfy);
        root_a[edge_n] = isqrt(ax * ax + ay * ay);
        scl_a[edge_n]  = int'(sc);
        @(negedge clk);
        r = (edge_n > 24) ? root_a[edge_n - 24] : 0;
        s = (edge_n > 1) ? scl_a[edge_n - 1] : 0;
        full = longint'(r) << s;
        if (full > 65535) begin em = 65535; eo = 1; end
        else begin em = int'(full); eo = 0; end
        check(cur_req, "mag", int'(mag_out), oe ? em : 0);
        check(cur_req, "ovr", int'(ovr_out), eo);
    endtask

    task automatic flush(int n);
        for (int i = 0; i < n; i++) step(16'h0, 16'h0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; x_in = '0; y_in = '0; fmt_sm = 1'b0; x_ce = 1'b1;
        y_ce = 1'b1; scale_sel = 2'b00; mag_oe = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset values at the ports
        check("R8", "mag in reset", int'(mag_out), 0);
        check("R8", "ovr in reset", int'(ovr_out), 0);
        rst_n = 1'b1;

        // R8 and R1: nonzero data right after reset; zeros until it lands
        cur_req = "R8";
        for (int i = 0; i < 24; i++) step(16'd3, 16'd4, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
        // R1: isolated impulse and back-to-back distinct samples
        cur_req = "R1";
        step(16'd1200, 16'd500, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
        for (int i = 0; i < 30; i++) step(16'(i * 97), 16'(i * 31), 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);

        // R2: known roots and the largest legal inputs
        cur_req = "R2";
        step(16'd0, 16'd0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
        step(16'h7fff, 16'h7fff, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
        step(16'h8001, 16'h8001, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
        step(16'hffff, 16'hffff, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1);
        for (int i = 0; i < 150; i++)
            step(16'($urandom), 16'($urandom), 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);

        // R3: -3/-4 in both codings, then random with alternating format
        cur_req = "R3";
        step(16'hfffd, 16'hfffc, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
        step(16'h8003, 16'h8004, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1);
        step(16'h8003, 16'h0004, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1);
        for (int i = 0; i < 150; i++)
            step(16'($urandom), 16'($urandom), 1'(i), 1'b1, 1'b1, 2'b00, 1'b1);

        // R4: scale changing every cycle, small to mid values
        cur_req = "R4";
        for (int i = 0; i < 150; i++)
            step(16'($urandom_range(0, 16'h1fff)), 16'($urandom_range(0, 16'h1fff)),
                 1'($urandom), 1'b1, 1'b1, 2'($urandom), 1'b1);

        // R5: large values so shifts overflow
        cur_req = "R5";
        for (int i = 0; i < 150; i++)
            step(16'($urandom) | 16'h4000, 16'($urandom), 1'b1, 1'b1, 1'b1, 2'($urandom), 1'b1);
        for (int i = 0; i < 60; i++)
            step(16'($urandom), 16'($urandom), 1'($urandom), 1'b1, 1'b1, 2'($urandom), 1'b1);

        // R6: capture enables toggling independently
        cur_req = "R6";
        for (int i = 0; i < 200; i++)
            step(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 2'($urandom), 1'b1);

        // R7: output gate toggling, overflow flag still visible
        cur_req = "R7";
        for (int i = 0; i < 200; i++)
            step(16'($urandom), 16'($urandom), 1'($urandom), 1'b1, 1'b1,
                 2'($urandom), 1'($urandom));

        cur_req = "R1";
        flush(30);

        done = 1;
        summary();
        $finish;
    end
endmodule